// File: doc/BRIEF.md
# Single-Character Shift-Or Byte Pattern Matcher

This block watches a byte stream and reports every place where one fixed byte string, chosen at elaboration time, ends. It accepts at most one character per clock, qualified by a valid strobe. A 256-entry lookup table, built from the pattern parameter, gives an m-bit mismatch mask for each byte value. In that mask, bit i is clear only when the byte equals the i-th pattern character. An active-low prefix vector is shifted up by one place and ORed with the mask of the incoming byte. Lane 0 of the vector is always 0, so a new attempt can start on every character.

Only the m-1 lower prefix lanes are stored in flip-flops. The top lane is never registered: its combinational value is the match check point. The match output is therefore high in the same cycle as the character that completes the pattern. Occurrences that overlap are all reported. Idle cycles, where valid is low, leave any partial match intact.

Top module: `shiftor_match`

## Requirements
- R1: The pattern is the `PATLEN`-byte parameter `PATTERN`. Character 1 (the first to arrive) sits in the most significant byte, so a string literal such as "aab" reads in stream order.
- R2: `match` is high in the same cycle as an accepted character exactly when that character and the `PATLEN`-1 accepted characters before it spell the pattern in order.
- R3: While `in_valid` is low, `match` is low, whatever the value of `in_char`.
- R4: Cycles with `in_valid` low neither advance nor clear progress. For example, "a", idle, "a", idle, "b" still matches "aab" on the "b".
- R5: A synchronous, active-high `rst` discards all partial progress. After reset, characters received before it never count toward a match.
- R6: Overlapping occurrences are all reported. For example, pattern "aa" over "aaa" flags the second and third characters.
- R7: Pattern "aab" over the stream "acaab" gives exactly one match, on the fifth character.
- R8: No match is flagged until at least `PATLEN` characters have been accepted since reset.
- R9: Over long random streams with random idle cycles, `match` equals a search of the received history on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_char` in this cycle |
| in_char | input | 8 | Incoming byte |
| match | output | 1 | High when the current accepted byte completes the pattern |

## Verification
The match result is due in the same cycle as the completing character, with no register in between. The bench therefore drives each character just after the falling edge and samples `match` one nanosecond later, before the next rising edge commits the prefix lanes. The reference history is updated only after that comparison, so the expected value always describes the character being presented. A reset that is asserted at one rising edge takes effect for the character presented in the following cycle, and the model clears its history at the same point.

// File: rtl/shiftor_match.sv
module shiftor_match #(
  parameter int PATLEN = 3,
  parameter logic [8*PATLEN-1:0] PATTERN = "aab"
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_char,
  output logic       match
);

  logic [PATLEN:1]   mask_tbl [256];
  logic [PATLEN:1]   mask;
  logic [PATLEN-1:0] lanes;
  logic [PATLEN:1]   lanes_nxt;

  always_comb begin
    for (int k = 0; k < 256; k++)
      for (int i = 1; i <= PATLEN; i++)
        mask_tbl[k][i] = (PATTERN[8*(PATLEN-i) +: 8] != 8'(k));
  end

  assign mask      = mask_tbl[in_char];
  assign lanes[0]  = 1'b0;
  assign lanes_nxt = lanes | mask;
  assign match     = in_valid & ~lanes_nxt[PATLEN];

  generate
    if (PATLEN > 1) begin : g_lanes
      logic [PATLEN-1:1] lane_q;
      always_ff @(posedge clk) begin
        if (rst)           lane_q <= '1;
        else if (in_valid) lane_q <= lanes_nxt[PATLEN-1:1];
      end
      assign lanes[PATLEN-1:1] = lane_q;
    end
  endgenerate

endmodule

// File: rtl/shiftor_match_chk.sv
module shiftor_match_chk #(
  parameter int PATLEN = 3,
  parameter logic [8*PATLEN-1:0] PATTERN = "aab"
) (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic [7:0] in_char,
  input logic       match
);
  localparam int CW = $clog2(PATLEN + 1) + 1;
  localparam logic [7:0] LAST_CH = PATTERN[7:0];
  localparam logic [7:0] PREV_CH = (PATLEN > 1) ? PATTERN[15:8] : 8'h00;

  logic [CW-1:0] seen;
  logic [7:0]    prev_ch;

  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (in_valid && seen < CW'(PATLEN)) seen <= seen + 1'b1;
    if (in_valid) prev_ch <= in_char;
  end

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> !match);

  assert_last_char_R2: assert property (@(posedge clk) disable iff (rst)
    match |-> in_char == LAST_CH);

  assert_enough_seen_R8: assert property (@(posedge clk) disable iff (rst)
    match |-> seen >= CW'(PATLEN - 1));

  assert_prev_char_R4: assert property (@(posedge clk) disable iff (rst)
    (match && PATLEN > 1) |-> prev_ch == PREV_CH);
endmodule

bind shiftor_match shiftor_match_chk #(.PATLEN(PATLEN), .PATTERN(PATTERN)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_char(in_char), .match(match)
);

// File: tb/shiftor_match_tb.sv
module shiftor_match_tb;
  localparam int LA = 3;
  localparam logic [8*LA-1:0] PA = "aab";
  localparam int LB = 2;
  localparam logic [8*LB-1:0] PB = "aa";

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_char = 8'h00;
  logic match_a, match_b;
  int checks = 0, fails = 0, hits_a = 0;
  logic [7:0] hist[$];

  always #2 clk = ~clk;

  shiftor_match #(.PATLEN(LA), .PATTERN(PA)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_char(in_char), .match(match_a));
  shiftor_match #(.PATLEN(LB), .PATTERN(PB)) u_dut_ovl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_char(in_char), .match(match_b));

  function automatic logic ref_hit(logic v, logic [7:0] c, int m, logic [8*LA-1:0] pat);
    if (!v) return 1'b0;
    if (hist.size() < m - 1) return 1'b0;
    if (c != pat[7:0]) return 1'b0;
    for (int j = 1; j < m; j++)
      if (hist[hist.size() - j] != pat[8*j +: 8]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: match=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic v, logic [7:0] c, logic r = 1'b0);
    logic ea, eb;
    @(negedge clk);
    in_valid = v; in_char = c; rst = r;
    #1;
    ea = ref_hit(v, c, LA, PA);
    eb = ref_hit(v, c, LB, {8'h00, PB});
    check({tag, " [aab]"}, match_a, ea);
    check({tag, " [aa]"}, match_b, eb);
    if (match_a === 1'b1) hits_a++;
    if (v) hist.push_back(c);
    if (r) hist.delete();
  endtask

  task automatic feed(string tag, string s);
    for (int i = 0; i < s.len(); i++) step(tag, 1'b1, s[i]);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        step("R5 reset state", 1'b0, 8'h00, 1'b1);
        step("R5 reset release", 1'b0, 8'h00);
        feed("R8 fresh b", "b");
        step("R5 flush", 1'b0, 8'h00, 1'b1);
        hits_a = 0;
        feed("R7 acaab", "acaab");
        checks++;
        if (hits_a != 1) begin
          fails++;
          $display("FAIL R7: matches=%0d expected 1", hits_a);
        end
        feed("R1 R2 separator", "cc");
        feed("R6 overlap aaa", "aaa");
        feed("R6 overlap aaab", "aaab");
        feed("R4 sep", "c");
        step("R4 gap", 1'b1, "a");
        step("R4 gap", 1'b0, "c");
        step("R4 gap", 1'b1, "a");
        step("R4 gap", 1'b0, "x");
        step("R4 gap", 1'b0, "x");
        step("R4 gap end", 1'b1, "b");
        feed("R3 sep", "aa");
        step("R3 idle b", 1'b0, "b");
        step("R3 then b", 1'b1, "b");
        feed("R5 partial", "aa");
        step("R5 mid reset", 1'b0, "b", 1'b1);
        step("R5 after reset", 1'b1, "b");
        feed("R5 after reset", "a");
        for (int n = 0; n < 4000; n++) begin
          int sel = $urandom_range(0, 9);
          logic [7:0] c = (sel < 5) ? "a" : (sel < 8) ? "b" : 8'($urandom);
          step("R9 random", $urandom_range(0, 3) != 0, c);
        end
      end
      begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule